// File: doc/BRIEF.md
# Serial Download Loader

This block fills a small on-chip program RAM from an asynchronous serial receive line after reset, so that a processor can start from code that was just downloaded. It first waits for a synchronisation character of all ones. It uses the way that character decodes to choose between a fast and a slow bit-rate divisor of the enable clock. After that, every good character is written to the next RAM location and sent back on the transmit line so the sender can confirm it.

A download ends in one of two ways: the configured byte limit is reached, or the receive line stays quiet for several character times. The loader then raises a one-cycle completion pulse and presents the fixed start address at which execution should begin. The transmit pin is modelled as open-drain: the block only requests a low level and otherwise leaves the line to a pull-up.

Frames are 8N1, least significant bit first. Each bit is oversampled 16 times and read at its centre. Characters with a bad stop bit are discarded and recorded in a sticky flag.

Top module: `serial_boot_loader`

## Requirements
- R1: After reset, ramWe, loadDone, txDrvLow and frameErr are 0 and entryAddr is 0.
- R2: No RAM write and no transmit activity happen until a character of value 8'hFF has been received with a valid stop bit. The sync character itself is neither stored nor echoed.
- R3: The receiver starts at FAST_DIV enable pulses per sample tick (16 ticks per bit). Any sync frame that is not a clean 8'hFF switches it permanently to SLOW_DIV. A later 8'hFF at the slow rate then starts the download.
- R4: The k-th stored byte (k from 0) is presented on ramData at ramAddr = START_ADDR + k, with ramWe high for exactly one clock.
- R5: Each stored byte is echoed on the transmit line at the selected rate as an 8N1 frame, LSB first. txDrvLow = 1 means the line is pulled low, and txDrvLow = 0 releases it high.
- R6: The download ends when the MAX_BYTES-th byte is stored, and not before.
- R7: Once the download has begun, it also ends when no start bit is seen for IDLE_CHARS character times (10 bits each), counted from the last start bit.
- R8: The end of a download gives a single one-cycle loadDone pulse. From that pulse on, entryAddr equals START_ADDR; before it, entryAddr is 0.
- R9: A frame whose stop bit samples low is neither stored nor echoed and does not advance the address. It sets frameErr, which stays at 1 until reset.
- R10: After loadDone, further received frames cause no RAM write, no echo and no further loadDone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clkEn | input | 1 | Bus-rate enable; the bit-rate divisors count these pulses |
| rxIn | input | 1 | Serial receive line, idle high |
| txDrvLow | output | 1 | Open-drain request: 1 pulls the transmit line low |
| ramAddr | output | ADDR_W | RAM write address |
| ramData | output | 8 | RAM write data |
| ramWe | output | 1 | RAM write strobe, one clock per byte |
| loadDone | output | 1 | One-cycle pulse when the download is complete |
| entryAddr | output | ADDR_W | Execution start address, valid from loadDone onward |
| frameErr | output | 1 | Sticky stop-bit error flag |

## Verification
A wrong rate choice or a wrong oversampling phase corrupts the very next character. That shows within one frame time as a missing or wrong RAM write, or as an echo that does not match the byte sent. A byte counter that is off by one moves the address of every later write and moves the completion pulse by a whole frame. A faulty idle counter moves loadDone by a fraction of a character time, so the bench brackets the expected instant on both sides. A broken error path becomes visible at the first bad frame: the address stops being contiguous, or a discarded byte is echoed.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
  localparam int OVERSAMPLE = 16;
  localparam int FRAME_BITS = 10;

  typedef struct packed {
    logic goSlow;   // switch to the slow divisor
    logic wrByte;   // store and echo the received byte
    logic clrIdle;  // restart the idle timer
    logic idleRun;  // idle timer counts
    logic markErr;  // set the sticky frame error
  } sblStrobe_t;

  typedef enum logic [1:0] {CT_SYNC, CT_LOAD, CT_DONE} ctState_t;
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_BREAK} rxState_t;
endpackage

// File: rtl/sbl_datapath.sv
module sbl_datapath
  import sbl_pkg::*;
#(
  parameter int FAST_DIV   = 16,
  parameter int SLOW_DIV   = 104,
  parameter int MAX_BYTES  = 192,
  parameter int IDLE_CHARS = 4,
  parameter int ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] START_ADDR = 'h40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              rxIn,
  input  sblStrobe_t        strobe,
  output logic              rxDone,
  output logic [7:0]        rxByte,
  output logic              rxStopOk,
  output logic              idleExpired,
  output logic              lastByte,
  output logic              txDrvLow,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [7:0]        ramData,
  output logic              frameErr
);
  localparam int DIV_W      = $clog2(SLOW_DIV + 1);
  localparam int CNT_W      = $clog2(MAX_BYTES + 1);
  localparam int IDLE_TICKS = IDLE_CHARS * FRAME_BITS * OVERSAMPLE;
  localparam int IDLE_W     = $clog2(IDLE_TICKS + 1);
  localparam logic [DIV_W-1:0] FAST_LAST = DIV_W'(FAST_DIV - 1);
  localparam logic [DIV_W-1:0] SLOW_LAST = DIV_W'(SLOW_DIV - 1);

  // receive line synchroniser
  logic [1:0] rxSync;
  logic       rxLine;
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) rxSync <= 2'b11;
    else       rxSync <= {rxSync[0], rxIn};
  assign rxLine = rxSync[1];

  // rate select and sample-tick prescaler
  logic             slowSel;
  logic [DIV_W-1:0] preCnt;
  logic             tick;
  assign tick = clkEn && (preCnt == (slowSel ? SLOW_LAST : FAST_LAST));

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      slowSel <= 1'b0;
      preCnt  <= '0;
    end else if (strobe.goSlow) begin
      slowSel <= 1'b1;
      preCnt  <= '0;
    end else if (clkEn) begin
      preCnt <= tick ? '0 : preCnt + 1'b1;
    end

  // receiver
  rxState_t   rxSt;
  logic [3:0] rxPh;
  logic [2:0] rxBit;
  logic [7:0] rxSh;
  logic       startDet;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      rxSt     <= RX_IDLE;
      rxPh     <= '0;
      rxBit    <= '0;
      rxSh     <= '0;
      rxDone   <= 1'b0;
      rxStopOk <= 1'b0;
      startDet <= 1'b0;
    end else begin
      rxDone   <= 1'b0;
      startDet <= 1'b0;
      if (tick) begin
        case (rxSt)
          RX_IDLE: if (!rxLine) begin
            rxSt     <= RX_START;
            rxPh     <= '0;
            startDet <= 1'b1;
          end
          RX_START: if (rxPh == 4'd7) begin
            rxPh  <= '0;
            rxBit <= '0;
            rxSt  <= rxLine ? RX_IDLE : RX_DATA;
          end else rxPh <= rxPh + 1'b1;
          RX_DATA: if (rxPh == 4'd15) begin
            rxPh <= '0;
            rxSh <= {rxLine, rxSh[7:1]};
            if (rxBit == 3'd7) rxSt <= RX_STOP;
            else               rxBit <= rxBit + 1'b1;
          end else rxPh <= rxPh + 1'b1;
          RX_STOP: if (rxPh == 4'd15) begin
            rxPh     <= '0;
            rxDone   <= 1'b1;
            rxStopOk <= rxLine;
            rxSt     <= rxLine ? RX_IDLE : RX_BREAK;
          end else rxPh <= rxPh + 1'b1;
          RX_BREAK: if (rxLine) rxSt <= RX_IDLE;
          default: rxSt <= RX_IDLE;
        endcase
      end
    end
  assign rxByte = rxSh;

  // idle timer in sample ticks
  logic [IDLE_W-1:0] idleCnt;
  assign idleExpired = (idleCnt == IDLE_W'(IDLE_TICKS));
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) idleCnt <= '0;
    else if (strobe.clrIdle || startDet) idleCnt <= '0;
    else if (strobe.idleRun && tick && !idleExpired) idleCnt <= idleCnt + 1'b1;

  // byte counter and RAM port
  logic [CNT_W-1:0] byteCnt;
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)              byteCnt <= '0;
    else if (strobe.wrByte) byteCnt <= byteCnt + 1'b1;
  assign lastByte = (byteCnt == CNT_W'(MAX_BYTES - 1));
  assign ramAddr  = START_ADDR + ADDR_W'(byteCnt);
  assign ramData  = rxByte;

  // echo transmitter with one pending slot
  logic       txBusy;
  logic [9:0] txSh;
  logic [3:0] txPh;
  logic [3:0] txBitCnt;
  logic       txPendV;
  logic [7:0] txPend;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      txBusy   <= 1'b0;
      txSh     <= '1;
      txPh     <= '0;
      txBitCnt <= '0;
      txPendV  <= 1'b0;
      txPend   <= '0;
    end else if (!txBusy) begin
      if (txPendV || strobe.wrByte) begin
        txBusy   <= 1'b1;
        txPh     <= '0;
        txBitCnt <= '0;
        txSh     <= {1'b1, (txPendV ? txPend : rxByte), 1'b0};
        txPendV  <= txPendV && strobe.wrByte;
        if (txPendV && strobe.wrByte) txPend <= rxByte;
      end
    end else begin
      if (strobe.wrByte) begin
        txPendV <= 1'b1;
        txPend  <= rxByte;
      end
      if (tick) begin
        if (txPh == 4'd15) begin
          txPh <= '0;
          txSh <= {1'b1, txSh[9:1]};
          if (txBitCnt == 4'd9) txBusy <= 1'b0;
          else                  txBitCnt <= txBitCnt + 1'b1;
        end else txPh <= txPh + 1'b1;
      end
    end
  assign txDrvLow = txBusy && !txSh[0];

  // sticky stop-bit error
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)               frameErr <= 1'b0;
    else if (strobe.markErr) frameErr <= 1'b1;
endmodule

// File: rtl/sbl_ctrl.sv
module sbl_ctrl
  import sbl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxDone,
  input  logic [7:0] rxByte,
  input  logic       rxStopOk,
  input  logic       idleExpired,
  input  logic       lastByte,
  output sblStrobe_t strobe,
  output logic       loadDone,
  output logic       inDone
);
  ctState_t st, nxt;

  always_comb begin
    strobe = '0;
    nxt    = st;
    case (st)
      CT_SYNC: if (rxDone) begin
        if (rxStopOk && rxByte == 8'hFF) begin
          nxt            = CT_LOAD;
          strobe.clrIdle = 1'b1;
        end else begin
          strobe.goSlow  = 1'b1;
          strobe.markErr = !rxStopOk;
        end
      end
      CT_LOAD: begin
        strobe.idleRun = 1'b1;
        if (rxDone) begin
          if (rxStopOk) begin
            strobe.wrByte = 1'b1;
            if (lastByte) nxt = CT_DONE;
          end else begin
            strobe.markErr = 1'b1;
          end
        end else if (idleExpired) begin
          nxt = CT_DONE;
        end
      end
      default: nxt = CT_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      st       <= CT_SYNC;
      loadDone <= 1'b0;
    end else begin
      st       <= nxt;
      loadDone <= (st == CT_LOAD) && (nxt == CT_DONE);
    end

  assign inDone = (st == CT_DONE);
endmodule

// File: rtl/serial_boot_loader.sv
module serial_boot_loader
  import sbl_pkg::*;
#(
  parameter int FAST_DIV   = 16,
  parameter int SLOW_DIV   = 104,
  parameter int MAX_BYTES  = 192,
  parameter int IDLE_CHARS = 4,
  parameter int ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] START_ADDR = 'h40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              rxIn,
  output logic              txDrvLow,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [7:0]        ramData,
  output logic              ramWe,
  output logic              loadDone,
  output logic [ADDR_W-1:0] entryAddr,
  output logic              frameErr
);
  sblStrobe_t strobe;
  logic       rxDone, rxStopOk, idleExpired, lastByte, inDone;
  logic [7:0] rxByte;

  sbl_datapath #(
    .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV), .MAX_BYTES(MAX_BYTES),
    .IDLE_CHARS(IDLE_CHARS), .ADDR_W(ADDR_W), .START_ADDR(START_ADDR)
  ) dp_i (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .rxIn(rxIn), .strobe(strobe),
    .rxDone(rxDone), .rxByte(rxByte), .rxStopOk(rxStopOk),
    .idleExpired(idleExpired), .lastByte(lastByte), .txDrvLow(txDrvLow),
    .ramAddr(ramAddr), .ramData(ramData), .frameErr(frameErr)
  );

  sbl_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .rxDone(rxDone), .rxByte(rxByte),
    .rxStopOk(rxStopOk), .idleExpired(idleExpired), .lastByte(lastByte),
    .strobe(strobe), .loadDone(loadDone), .inDone(inDone)
  );

  assign ramWe     = strobe.wrByte;
  assign entryAddr = inDone ? START_ADDR : '0;
endmodule

// File: rtl/sbl_checker.sv
module sbl_checker #(
  parameter int ADDR_W    = 16,
  parameter int MAX_BYTES = 192,
  parameter logic [ADDR_W-1:0] START_ADDR = 'h40
) (
  input logic              clk,
  input logic              rstN,
  input logic              txDrvLow,
  input logic [ADDR_W-1:0] ramAddr,
  input logic              ramWe,
  input logic              loadDone,
  input logic [ADDR_W-1:0] entryAddr,
  input logic              frameErr
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = START_ADDR + ADDR_W'(MAX_BYTES - 1);

  logic              haveWr, seenDone;
  logic [ADDR_W-1:0] lastAddr;
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      haveWr   <= 1'b0;
      seenDone <= 1'b0;
      lastAddr <= '0;
    end else begin
      if (ramWe) begin
        haveWr   <= 1'b1;
        lastAddr <= ramAddr;
      end
      if (loadDone) seenDone <= 1'b1;
    end

  assert_addr_window_R4: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (ramAddr >= START_ADDR && ramAddr <= LAST_ADDR));
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ramWe && haveWr) |-> ramAddr == lastAddr + 1'b1);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> !loadDone);
  assert_entry_on_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |-> entryAddr == START_ADDR);
  assert_entry_zero_before_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!seenDone && !loadDone) |-> entryAddr == '0);
  assert_quiet_after_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    seenDone |-> (!ramWe && !loadDone));
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> frameErr);
  assert_tx_after_store_R2: assert property (@(posedge clk) disable iff (!rstN)
    txDrvLow |-> haveWr);
endmodule

bind serial_boot_loader sbl_checker #(
  .ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES), .START_ADDR(START_ADDR)
) chk_i (
  .clk(clk), .rstN(rstN), .txDrvLow(txDrvLow), .ramAddr(ramAddr),
  .ramWe(ramWe), .loadDone(loadDone), .entryAddr(entryAddr), .frameErr(frameErr)
);

// File: tb/serial_boot_loader_tb.sv
module serial_boot_loader_tb_top;
  localparam int FAST_DIV  = 2;
  localparam int SLOW_DIV  = 5;
  localparam int MAX_BYTES = 5;
  localparam int FAST_BIT  = FAST_DIV * 16;
  localparam int SLOW_BIT  = SLOW_DIV * 16;
  localparam logic [15:0] ENTRY = 16'h0040;

  // stimulus byte and expected write address
  localparam logic [23:0] VEC [0:4] = '{
    {8'hA5, 16'h0040}, {8'h3C, 16'h0041}, {8'h00, 16'h0042},
    {8'hFF, 16'h0043}, {8'h81, 16'h0044}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clkEn = 1'b1;
  logic rxIn = 1'b1;
  logic txDrvLow, ramWe, loadDone, frameErr;
  logic [15:0] ramAddr, entryAddr;
  logic [7:0] ramData;

  always #5 clk = ~clk;

  serial_boot_loader #(
    .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV), .MAX_BYTES(MAX_BYTES),
    .IDLE_CHARS(4), .ADDR_W(16), .START_ADDR(ENTRY)
  ) dut_i (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .rxIn(rxIn), .txDrvLow(txDrvLow),
    .ramAddr(ramAddr), .ramData(ramData), .ramWe(ramWe), .loadDone(loadDone),
    .entryAddr(entryAddr), .frameErr(frameErr)
  );

  int nChecks = 0;
  int nFail = 0;
  int monBit = FAST_BIT;

  // RAM write and completion log
  int wrCount, doneCount;
  logic [15:0] wrAddr [0:15];
  logic [7:0]  wrData [0:15];
  logic [15:0] doneEntry;
  always @(negedge clk) begin
    if (!rstN) begin
      wrCount = 0; doneCount = 0; doneEntry = '0;
    end else begin
      if (ramWe) begin
        if (wrCount < 16) begin
          wrAddr[wrCount] = ramAddr;
          wrData[wrCount] = ramData;
        end
        wrCount++;
      end
      if (loadDone) begin
        doneCount++;
        doneEntry = entryAddr;
      end
    end
  end

  // echo monitor on the open-drain line
  int echoCount, echoBad;
  logic [7:0] echoData [0:15];
  initial begin
    echoCount = 0; echoBad = 0;
    forever begin
      @(negedge clk);
      if (!rstN) begin
        echoCount = 0; echoBad = 0;
      end else if (txDrvLow) begin
        logic [7:0] b;
        repeat (monBit / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (monBit) @(negedge clk);
          b[i] = ~txDrvLow;
        end
        repeat (monBit) @(negedge clk);
        if (txDrvLow) echoBad++;
        if (echoCount < 16) echoData[echoCount] = b;
        echoCount++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] d, input int bitClks, input logic stopV);
    @(negedge clk) rxIn = 1'b0;
    repeat (bitClks) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxIn = d[i];
      repeat (bitClks) @(negedge clk);
    end
    rxIn = stopV;
    repeat (bitClks) @(negedge clk);
    rxIn = 1'b1;
    repeat (bitClks) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    rxIn = 1'b1;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    // R1: reset state
    doReset();
    check(ramWe == 1'b0,    "R1 ramWe",     ramWe, 0);
    check(loadDone == 1'b0, "R1 loadDone",  loadDone, 0);
    check(txDrvLow == 1'b0, "R1 txDrvLow",  txDrvLow, 0);
    check(frameErr == 1'b0, "R1 frameErr",  frameErr, 0);
    check(entryAddr == 16'h0, "R1 entryAddr", entryAddr, 0);

    // fast-rate download ended by the byte limit, table driven
    monBit = FAST_BIT;
    sendByte(8'hFF, FAST_BIT, 1'b1);
    check(wrCount == 0 && echoCount == 0, "R2 sync not stored", wrCount, 0);
    for (int i = 0; i < 5; i++) begin
      if (i == 4) check(doneCount == 0, "R6 no early done", doneCount, 0);
      sendByte(VEC[i][23:16], FAST_BIT, 1'b1);
      check(wrCount == i + 1, "R4 write count", wrCount, i + 1);
      check(wrAddr[i] == VEC[i][15:0], "R4 address", wrAddr[i], VEC[i][15:0]);
      check(wrData[i] == VEC[i][23:16], "R4 data", wrData[i], VEC[i][23:16]);
    end
    check(doneCount == 1, "R6 done at limit", doneCount, 1);
    check(doneEntry == ENTRY, "R8 entry at pulse", doneEntry, ENTRY);
    check(entryAddr == ENTRY, "R8 entry held", entryAddr, ENTRY);
    repeat (12 * FAST_BIT) @(negedge clk);
    check(echoCount == 5 && echoBad == 0, "R5 echo count", echoCount, 5);
    for (int i = 0; i < 5; i++)
      check(echoData[i] == VEC[i][23:16], "R5 echo data", echoData[i], VEC[i][23:16]);
    // R10: frames after completion are ignored
    sendByte(8'h77, FAST_BIT, 1'b1);
    repeat (12 * FAST_BIT) @(negedge clk);
    check(wrCount == 5, "R10 no write", wrCount, 5);
    check(echoCount == 5, "R10 no echo", echoCount, 5);
    check(doneCount == 1, "R10 no second done", doneCount, 1);

    // slow-rate download ended by idle time
    doReset();
    monBit = SLOW_BIT;
    sendByte(8'hFF, SLOW_BIT, 1'b1);
    check(wrCount == 0 && echoCount == 0, "R3 fast decode rejected", wrCount, 0);
    sendByte(8'hFF, SLOW_BIT, 1'b1);
    check(wrCount == 0, "R2 sync not stored", wrCount, 0);
    sendByte(8'h5A, SLOW_BIT, 1'b1);
    sendByte(8'hC3, SLOW_BIT, 1'b1);
    check(wrCount == 2, "R3 slow bytes stored", wrCount, 2);
    check(wrAddr[0] == 16'h0040 && wrData[0] == 8'h5A, "R3 first slow byte", wrData[0], 8'h5A);
    check(wrAddr[1] == 16'h0041 && wrData[1] == 8'hC3, "R4 second slow byte", wrData[1], 8'hC3);
    repeat (2000) @(negedge clk);
    check(doneCount == 0, "R7 not before idle time", doneCount, 0);
    check(entryAddr == 16'h0, "R8 entry zero before done", entryAddr, 0);
    repeat (600) @(negedge clk);
    check(doneCount == 1, "R7 done after idle time", doneCount, 1);
    check(echoCount == 2 && echoBad == 0, "R5 slow echo count", echoCount, 2);
    check(echoData[0] == 8'h5A && echoData[1] == 8'hC3, "R5 slow echo data", echoData[1], 8'hC3);

    // stop-bit error handling
    doReset();
    monBit = FAST_BIT;
    sendByte(8'hFF, FAST_BIT, 1'b1);
    sendByte(8'h12, FAST_BIT, 1'b0);
    check(wrCount == 0, "R9 bad frame not stored", wrCount, 0);
    check(frameErr == 1'b1, "R9 flag set", frameErr, 1);
    sendByte(8'h34, FAST_BIT, 1'b1);
    check(wrCount == 1, "R9 good frame stored", wrCount, 1);
    check(wrAddr[0] == 16'h0040 && wrData[0] == 8'h34, "R9 address not advanced", wrAddr[0], 16'h0040);
    repeat (1500) @(negedge clk);
    check(doneCount == 1, "R7 fast idle end", doneCount, 1);
    check(frameErr == 1'b1, "R9 flag sticky", frameErr, 1);
    check(echoCount == 1 && echoData[0] == 8'h34, "R9 bad frame not echoed", echoCount, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule